// File: doc/BRIEF.md
# Amplifier protection fault controller

This block turns the protection conditions of a class-D output stage into one output-enable decision and an active-low fault drive for an open-drain pin. It reads an active-low shutdown control, a short-circuit detect pulse, a DC-fault level, a digital die temperature and an active-low power-on reset. It drives an output enable for the bridge, the fault pull-down and a flag that marks the end of the startup delay.

Each protection source follows its own rule. A short circuit is latched and cleared by taking shutdown low. A DC fault is latched and survives shutdown, so only a power-on reset clears it. An over-temperature condition disables the bridge with hysteresis, clears by itself and never appears on the fault pin. The bridge is enabled only after a startup delay has run out. That delay restarts whenever shutdown is released. If the fault pin is wired back to the shutdown input, a short circuit clears itself and the amplifier restarts.

The shutdown, short and DC inputs pass through a `SYNC_STAGES`-deep synchronizer. The die temperature is assumed to be synchronous to the clock.

Top module: `amp_prot_ctrl`

## Requirements
- R1: While `rst_ni` is low: `out_en_o` is 0, `fault_no` is 1 (released) and `start_done_o` is 0.
- R2: `shdn_ni` rises with no fault present. `out_en_o` and `start_done_o` then go to 1 exactly `SYNC_STAGES + STARTUP_CYC` clock edges later. They are still 0 one edge before that.
- R3: Each rising edge of `shdn_ni` restarts the startup delay from zero, and so does each power-on reset.
- R4: `shdn_ni` falls. `out_en_o` then goes to 0 `SYNC_STAGES` edges later, and `start_done_o` goes to 0 one edge after that.
- R5: The over-temperature state sets when `die_temp_i` > `TRIP_TEMP` (150). It clears only when `die_temp_i` <= `TRIP_TEMP - HYST_TEMP` (135). Between those limits it keeps its previous value. `out_en_o` follows this state one edge after the temperature changes.
- R6: The over-temperature state never drives `fault_no` low. When it clears while shutdown is high and the startup delay is done, `out_en_o` returns with no new startup delay.
- R7: A one-cycle `sc_det_i` pulse while shutdown is high drives `fault_no` low and `out_en_o` low `SYNC_STAGES + 1` edges later. Both stay that way while shutdown remains high.
- R8: The short-circuit latch clears `SYNC_STAGES + 1` edges after `shdn_ni` goes low. A short-circuit pulse that arrives while shutdown is low is ignored.
- R9: With `fault_no` wired-ANDed into `shdn_ni`, a short-circuit pulse holds the fault pin low for `SYNC_STAGES + 1` cycles, then releases it. The outputs are enabled again after a new startup delay.
- R10: `dc_flt_i` high drives `fault_no` low and `out_en_o` low `SYNC_STAGES + 1` edges later. This state survives `dc_flt_i` returning low and survives any cycling of `shdn_ni`.
- R11: A power-on reset clears a latched DC fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| shdn_ni | input | 1 | Shutdown control, low = shut down |
| sc_det_i | input | 1 | Short-circuit detect pulse |
| dc_flt_i | input | 1 | DC-fault detect level |
| die_temp_i | input | TEMP_W | Die temperature, unsigned degrees C |
| out_en_o | output | 1 | Output bridge enable, 0 = Hi-Z |
| fault_no | output | 1 | Fault pull-down, 0 = pull pin low, 1 = release |
| start_done_o | output | 1 | Startup delay has elapsed |

## Verification
Each result has a fixed delay after its stimulus, counted in clock edges:
- Temperature decisions: one edge.
- Shutdown-driven disable: `SYNC_STAGES` edges.
- Short-circuit and DC faults: `SYNC_STAGES + 1` edges.
- Enable after a release: `SYNC_STAGES + STARTUP_CYC` edges.

The bench drives its inputs just after a rising edge and advances a counted number of edges before it samples. For the startup and shutdown paths it checks both the edge before the change and the edge of the change, so an early or late output is caught. In the auto-recovery loop the bench counts from the fault release, where the new startup delay begins.

// File: rtl/amp_prot_pkg.sv
package amp_prot_pkg;
  typedef struct packed {
    logic sc;
    logic dc;
    logic therm;
  } prot_flags_t;

  function automatic logic any_reported(prot_flags_t f);
    return f.sc | f.dc;
  endfunction

  function automatic logic any_blocking(prot_flags_t f);
    return f.sc | f.dc | f.therm;
  endfunction
endpackage

// File: rtl/amp_prot_sync.sv
module amp_prot_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [WIDTH-1:0] stg_q [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/amp_prot_thermal.sv
module amp_prot_thermal #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_TEMP = 150,
  parameter int HYST_TEMP = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TripLvl = TEMP_W'(TRIP_TEMP);
  localparam logic [TEMP_W-1:0] ClrLvl  = TEMP_W'(TRIP_TEMP - HYST_TEMP);

  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else if (hot_q) hot_q <= (temp_i > ClrLvl);
    else hot_q <= (temp_i > TripLvl);
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/amp_prot_latch.sv
module amp_prot_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sc_i,
  input  logic dc_i,
  output logic sc_lat_o,
  output logic dc_lat_o
);
  logic sc_q, dc_q;

  // shutdown clears the short latch and masks new short events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sc_q <= 1'b0;
    else if (!run_i) sc_q <= 1'b0;
    else if (sc_i) sc_q <= 1'b1;
  end

  // DC latch: only power-on reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dc_q <= 1'b0;
    else if (dc_i) dc_q <= 1'b1;
  end

  assign sc_lat_o = sc_q;
  assign dc_lat_o = dc_q;
endmodule

// File: rtl/amp_prot_startup.sv
module amp_prot_startup #(
  parameter int STARTUP_CYC = 1400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CntW = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
  localparam logic [CntW-1:0] LastCnt = CntW'(STARTUP_CYC - 1);

  logic [CntW-1:0] cnt_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LastCnt) done_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/amp_prot_ctrl.sv
module amp_prot_ctrl
  import amp_prot_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int TRIP_TEMP   = 150,
  parameter int HYST_TEMP   = 15,
  parameter int STARTUP_CYC = 1400000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shdn_ni,
  input  logic              sc_det_i,
  input  logic              dc_flt_i,
  input  logic [TEMP_W-1:0] die_temp_i,
  output logic              out_en_o,
  output logic              fault_no,
  output logic              start_done_o
);
  logic [2:0]  raw_in, sync_out;
  logic        shdn_s, sc_s, dc_s;
  logic        sc_lat, dc_lat, therm_hot, st_done;
  prot_flags_t flags;

  assign raw_in = {shdn_ni, sc_det_i, dc_flt_i};

  amp_prot_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign shdn_s = sync_out[2];
  assign sc_s   = sync_out[1];
  assign dc_s   = sync_out[0];

  amp_prot_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (shdn_s),
    .sc_i    (sc_s),
    .dc_i    (dc_s),
    .sc_lat_o(sc_lat),
    .dc_lat_o(dc_lat)
  );

  amp_prot_thermal #(
    .TEMP_W(TEMP_W), .TRIP_TEMP(TRIP_TEMP), .HYST_TEMP(HYST_TEMP)
  ) u_therm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(die_temp_i),
    .hot_o (therm_hot)
  );

  amp_prot_startup #(.STARTUP_CYC(STARTUP_CYC)) u_start (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (shdn_s),
    .done_o(st_done)
  );

  assign flags        = '{sc: sc_lat, dc: dc_lat, therm: therm_hot};
  assign out_en_o     = shdn_s & st_done & ~any_blocking(flags);
  assign fault_no     = ~any_reported(flags);
  assign start_done_o = st_done;
endmodule

// File: rtl/amp_prot_ctrl_chk.sv
module amp_prot_ctrl_chk #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_TEMP = 150,
  parameter int HYST_TEMP = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              shdn_s,
  input logic              sc_lat,
  input logic              dc_lat,
  input logic              therm_hot,
  input logic [TEMP_W-1:0] die_temp_i,
  input logic              start_done_o
);
  localparam logic [TEMP_W-1:0] TripLvl = TEMP_W'(TRIP_TEMP);
  localparam logic [TEMP_W-1:0] ClrLvl  = TEMP_W'(TRIP_TEMP - HYST_TEMP);

  p_dc_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_lat |=> dc_lat);

  p_sc_clear_by_shdn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sc_lat) |-> !$past(shdn_s));

  p_sc_set_needs_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sc_lat) |-> $past(shdn_s));

  p_therm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_hot && die_temp_i > ClrLvl) |=> therm_hot);

  p_therm_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!therm_hot && die_temp_i <= TripLvl) |=> !therm_hot);

  p_startup_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_s |=> !start_done_o);
endmodule

bind amp_prot_ctrl amp_prot_ctrl_chk #(
  .TEMP_W(TEMP_W), .TRIP_TEMP(TRIP_TEMP), .HYST_TEMP(HYST_TEMP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shdn_s      (shdn_s),
  .sc_lat      (sc_lat),
  .dc_lat      (dc_lat),
  .therm_hot   (therm_hot),
  .die_temp_i  (die_temp_i),
  .start_done_o(start_done_o)
);

// File: tb/amp_prot_ctrl_tb_top.sv
module amp_prot_ctrl_tb_top;
  localparam int N    = 20;
  localparam int SYNC = 2;
  localparam int NVEC = 9;
  // {temperature, expected out_en} walked in order (hysteresis depends on order)
  localparam logic [8:0] THERM_VEC [NVEC] = '{
    {8'd100, 1'b1}, {8'd150, 1'b1}, {8'd151, 1'b0}, {8'd140, 1'b0},
    {8'd136, 1'b0}, {8'd135, 1'b1}, {8'd149, 1'b1}, {8'd200, 1'b0},
    {8'd135, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shdn_drv = 1'b0;
  logic       auto_en = 1'b0;
  logic       sc = 1'b0;
  logic       dc = 1'b0;
  logic [7:0] temp = 8'd25;
  logic       shdn_net, out_en, fault_n, st_done;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  // open-drain wired-AND of the fault pin into shutdown when auto-recovery is strapped
  assign shdn_net = shdn_drv & (fault_n | ~auto_en);

  amp_prot_ctrl #(.STARTUP_CYC(N), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .shdn_ni     (shdn_net),
    .sc_det_i    (sc),
    .dc_flt_i    (dc),
    .die_temp_i  (temp),
    .out_en_o    (out_en),
    .fault_no    (fault_n),
    .start_done_o(st_done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_up(input string tag);
    step(SYNC + N - 1);
    chk({tag, " en early"}, out_en, 1'b0);
    chk({tag, " done early"}, st_done, 1'b0);
    step(1);
    chk({tag, " en due"}, out_en, 1'b1);
    chk({tag, " done due"}, st_done, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 en in reset", out_en, 1'b0);
    chk("R1 fault in reset", fault_n, 1'b1);
    chk("R1 done in reset", st_done, 1'b0);
    rst_n = 1'b1;
    shdn_drv = 1'b1;
    wait_up("R2 first release");

    // thermal table, one edge latency
    for (int i = 0; i < NVEC; i++) begin
      temp = THERM_VEC[i][8:1];
      step(1);
      chk($sformatf("R5 temp %0d", THERM_VEC[i][8:1]), out_en, THERM_VEC[i][0]);
      chk("R6 thermal not on fault pin", fault_n, 1'b1);
    end
    temp = 8'd25;
    step(1);

    // shutdown disable latency
    shdn_drv = 1'b0;
    step(SYNC - 1);
    chk("R4 en before due", out_en, 1'b1);
    step(1);
    chk("R4 en off", out_en, 1'b0);
    step(1);
    chk("R4 done cleared", st_done, 1'b0);
    shdn_drv = 1'b1;
    wait_up("R3 restart");

    // short circuit, no auto-recovery
    sc = 1'b1; step(1); sc = 1'b0;
    step(SYNC - 1);
    chk("R7 fault before due", fault_n, 1'b1);
    step(1);
    chk("R7 fault low", fault_n, 1'b0);
    chk("R7 en off", out_en, 1'b0);
    step(10);
    chk("R7 latch held", fault_n, 1'b0);
    shdn_drv = 1'b0;
    step(SYNC);
    chk("R8 latch before clear", fault_n, 1'b0);
    step(1);
    chk("R8 latch cleared", fault_n, 1'b1);
    sc = 1'b1; step(1); sc = 1'b0;
    step(SYNC + 3);
    chk("R8 sc ignored in shutdown", fault_n, 1'b1);
    shdn_drv = 1'b1;
    wait_up("R8 re-enable");

    // auto-recovery loop
    auto_en = 1'b1;
    sc = 1'b1; step(1); sc = 1'b0;
    step(SYNC);
    chk("R9 fault asserted", fault_n, 1'b0);
    step(SYNC);
    chk("R9 fault still low", fault_n, 1'b0);
    step(1);
    chk("R9 fault released", fault_n, 1'b1);
    chk("R9 en off during restart", out_en, 1'b0);
    wait_up("R9 auto restart");
    auto_en = 1'b0;

    // DC fault survives shutdown cycling
    dc = 1'b1;
    step(SYNC + 1);
    chk("R10 fault low", fault_n, 1'b0);
    chk("R10 en off", out_en, 1'b0);
    dc = 1'b0;
    shdn_drv = 1'b0;
    step(5);
    shdn_drv = 1'b1;
    step(SYNC + N + 5);
    chk("R10 fault after shdn cycle", fault_n, 1'b0);
    chk("R10 en after shdn cycle", out_en, 1'b0);
    chk("R10 done after shdn cycle", st_done, 1'b1);

    // power-on reset clears DC
    rst_n = 1'b0;
    #1;
    chk("R11 fault in reset", fault_n, 1'b1);
    chk("R1 done cleared by reset", st_done, 1'b0);
    step(1);
    rst_n = 1'b1;
    wait_up("R11 R3 after reset");
    chk("R11 fault clear", fault_n, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule